// File: doc/BRIEF.md
# DSP Effective Address Generator

This block turns a 6-bit operand specifier into a memory operand address for a DSP data path. The upper three bits of the specifier pick an addressing mode. The lower three bits pick one of eight address registers. Each address register has an offset register with the same index. In the same step the block computes the address, and it writes back any post-modification or pre-decrement of the chosen address register. All arithmetic is plain linear arithmetic that wraps at the register width.

Mode `110` does not use a register. Register code `000` under that mode is an absolute address, and code `100` is immediate data. In both cases the operand comes from an extension word that follows the instruction, so the block flags that the extension word is needed. Any other register code under mode `110` is flagged as illegal. The address output is combinational from the current register contents. The register update lands on the clock edge where the execute strobe is high. A load port presets any address or offset register. Both register banks are visible as flat output vectors.

Top module: `dsp_ea_gen`

## Requirements
- R1: While reset is asserted, all eight address registers and all eight offset registers read zero.
- R2: Mode `000` presents Rn as the address and, on an executed edge, replaces Rn with Rn−Nn. Mode `001` does the same with Rn+Nn.
- R3: Mode `010` presents Rn and, on an executed edge, decrements Rn by one. Mode `011` presents Rn and increments Rn by one.
- R4: Mode `100` presents Rn and mode `101` presents Rn+Nn. Neither mode changes any register.
- R5: Mode `111` presents Rn−1 as the address. On an executed edge that same value is stored into Rn.
- R6: Mode `110` with register code `000` presents the extension word as the address, with need-extension 1, immediate 0 and illegal 0. No register changes.
- R7: Mode `110` with register code `100` presents the extension word as the operand, with need-extension 1, immediate 1 and illegal 0. No register changes.
- R8: Mode `110` with any other register code sets illegal to 1 and need-extension and immediate to 0. It drives the address to zero and leaves all registers unchanged.
- R9: Every address and register update wraps modulo 2^AW.
- R10: With the execute strobe low, no register changes. An executed operation changes at most the selected address register and never changes an offset register.
- R11: The load port writes its data into address register `idx` (select 0) or offset register `idx` (select 1) on the next edge. A load takes precedence over an executed update of the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_i | input | 1 | Execute strobe; commits the register update on this edge |
| ea_i | input | 6 | Operand specifier: [5:3] mode, [2:0] register code |
| ext_i | input | AW | Extension word (absolute address or immediate data) |
| ld_en_i | input | 1 | Load port write enable |
| ld_sel_i | input | 1 | Load target bank: 0 address register, 1 offset register |
| ld_idx_i | input | 3 | Load target index |
| ld_data_i | input | AW | Load data |
| addr_o | output | AW | Operand address (or immediate operand) |
| imm_o | output | 1 | Operand is immediate data |
| need_ext_o | output | 1 | Instruction needs an extension word |
| illegal_o | output | 1 | Specifier encoding is illegal |
| r_flat_o | output | 8*AW | Address registers, R0 in the low bits |
| n_flat_o | output | 8*AW | Offset registers, N0 in the low bits |

## Verification
The bench builds the block with AW=8, not the default 16. With that width, random register and offset values land on the wrap boundary often, and the directed cases reach 0x00−1 and 0xFF+1 in a single step. The narrow width also lets random load and execute mixes make same-register load/update collisions and illegal mode-`110` codes common. With 16 bits these cases would be rare.

// File: rtl/dsp_ea_pkg.sv
package dsp_ea_pkg;
  localparam int NREG  = 8;
  localparam int IDXW  = 3;
  localparam int MODEW = 3;

  typedef enum logic [2:0] {
    A_RN, A_RN_ADD_N, A_RN_DEC, A_EXT, A_ZERO
  } asel_e;

  typedef enum logic [2:0] {
    U_NONE, U_SUB_N, U_ADD_N, U_DEC, U_INC
  } usel_e;

  typedef struct packed {
    asel_e asel;
    usel_e usel;
    logic  need_ext;
    logic  imm;
    logic  illegal;
  } ea_ctl_t;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import dsp_ea_pkg::*;
(
  input  logic [MODEW+IDXW-1:0] ea,
  output ea_ctl_t               ctl
);
  logic [MODEW-1:0] mode;
  logic [IDXW-1:0]  rcode;

  assign mode  = ea[MODEW+IDXW-1:IDXW];
  assign rcode = ea[IDXW-1:0];

  always_comb begin
    ctl = '{asel: A_RN, usel: U_NONE, need_ext: 1'b0, imm: 1'b0, illegal: 1'b0};
    unique case (mode)
      3'b000: ctl.usel = U_SUB_N;
      3'b001: ctl.usel = U_ADD_N;
      3'b010: ctl.usel = U_DEC;
      3'b011: ctl.usel = U_INC;
      3'b100: ctl.usel = U_NONE;
      3'b101: ctl.asel = A_RN_ADD_N;
      3'b111: begin
        ctl.asel = A_RN_DEC;
        ctl.usel = U_DEC;
      end
      default: begin
        if (rcode == 3'b000 || rcode == 3'b100) begin
          ctl.asel     = A_EXT;
          ctl.need_ext = 1'b1;
          ctl.imm      = rcode[2];
        end else begin
          ctl.asel    = A_ZERO;
          ctl.illegal = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/ea_addr_unit.sv
module ea_addr_unit
  import dsp_ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] rn,
  input  logic [AW-1:0] nn,
  input  logic [AW-1:0] ext,
  input  asel_e         asel,
  input  usel_e         usel,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] r_next,
  output logic          upd
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] rn_dec, rn_inc, rn_addn, rn_subn;

  assign rn_dec  = rn - ONE;
  assign rn_inc  = rn + ONE;
  assign rn_addn = rn + nn;
  assign rn_subn = rn - nn;

  always_comb begin
    unique case (asel)
      A_RN_ADD_N: addr = rn_addn;
      A_RN_DEC:   addr = rn_dec;
      A_EXT:      addr = ext;
      A_ZERO:     addr = '0;
      default:    addr = rn;
    endcase
  end

  always_comb begin
    upd = 1'b1;
    unique case (usel)
      U_SUB_N: r_next = rn_subn;
      U_ADD_N: r_next = rn_addn;
      U_DEC:   r_next = rn_dec;
      U_INC:   r_next = rn_inc;
      default: begin
        r_next = rn;
        upd    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ea_regfile.sv
module ea_regfile
  import dsp_ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDXW-1:0]    rd_idx,
  output logic [AW-1:0]      rn,
  output logic [AW-1:0]      nn,
  input  logic               upd_en,
  input  logic [AW-1:0]      upd_data,
  input  logic               ld_en,
  input  logic               ld_sel,
  input  logic [IDXW-1:0]    ld_idx,
  input  logic [AW-1:0]      ld_data,
  output logic [NREG*AW-1:0] r_flat,
  output logic [NREG*AW-1:0] n_flat
);
  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic [AW-1:0] r_q, r_d, n_q;
    logic          r_we, n_we, ld_hit;

    assign ld_hit = ld_en && (ld_idx == IDXW'(gi));

    always_comb begin
      r_we = 1'b0;
      r_d  = upd_data;
      if (upd_en && rd_idx == IDXW'(gi)) r_we = 1'b1;
      if (ld_hit && !ld_sel) begin
        r_we = 1'b1;
        r_d  = ld_data;
      end
      n_we = ld_hit && ld_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '0;
        n_q <= '0;
      end else begin
        if (r_we) r_q <= r_d;
        if (n_we) n_q <= ld_data;
      end
    end

    assign r_flat[gi*AW +: AW] = r_q;
    assign n_flat[gi*AW +: AW] = n_q;
  end

  assign rn = r_flat[rd_idx*AW +: AW];
  assign nn = n_flat[rd_idx*AW +: AW];
endmodule

// File: rtl/dsp_ea_gen.sv
module dsp_ea_gen
  import dsp_ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_i,
  input  logic [5:0]         ea_i,
  input  logic [AW-1:0]      ext_i,
  input  logic               ld_en_i,
  input  logic               ld_sel_i,
  input  logic [2:0]         ld_idx_i,
  input  logic [AW-1:0]      ld_data_i,
  output logic [AW-1:0]      addr_o,
  output logic               imm_o,
  output logic               need_ext_o,
  output logic               illegal_o,
  output logic [8*AW-1:0]    r_flat_o,
  output logic [8*AW-1:0]    n_flat_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_sync;
  ea_ctl_t       ctl;
  logic [AW-1:0] rn, nn, r_next;
  logic          upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  ea_decode u_decode (
    .ea  (ea_i),
    .ctl (ctl)
  );

  ea_addr_unit #(.AW(AW)) u_addr (
    .rn     (rn),
    .nn     (nn),
    .ext    (ext_i),
    .asel   (ctl.asel),
    .usel   (ctl.usel),
    .addr   (addr_o),
    .r_next (r_next),
    .upd    (upd)
  );

  ea_regfile #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .rd_idx   (ea_i[IDXW-1:0]),
    .rn       (rn),
    .nn       (nn),
    .upd_en   (exec_i && upd && !ctl.illegal),
    .upd_data (r_next),
    .ld_en    (ld_en_i),
    .ld_sel   (ld_sel_i),
    .ld_idx   (ld_idx_i),
    .ld_data  (ld_data_i),
    .r_flat   (r_flat_o),
    .n_flat   (n_flat_o)
  );

  assign imm_o      = ctl.imm;
  assign need_ext_o = ctl.need_ext;
  assign illegal_o  = ctl.illegal;
endmodule

// File: rtl/dsp_ea_gen_chk.sv
module dsp_ea_gen_chk #(
  parameter int AW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exec_i,
  input logic [5:0]      ea_i,
  input logic            ld_en_i,
  input logic [AW-1:0]   addr_o,
  input logic            imm_o,
  input logic            need_ext_o,
  input logic            illegal_o,
  input logic [8*AW-1:0] r_flat_o,
  input logic [8*AW-1:0] n_flat_o
);
  logic [2:0]    idx_q;
  logic [AW-1:0] r_sel;

  always_ff @(posedge clk) idx_q <= ea_i[2:0];
  assign r_sel = r_flat_o[idx_q*AW +: AW];

  // R8
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!need_ext_o && !imm_o && addr_o == '0));

  // R7
  imm_needs_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm_o |-> need_ext_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_i && !ld_en_i) |=> ($stable(r_flat_o) && $stable(n_flat_o)));

  // R10
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en_i) |=> $stable(n_flat_o));

  // R4
  no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !ld_en_i && (ea_i[5:3] == 3'b100 || ea_i[5:3] == 3'b101))
      |=> $stable(r_flat_o));

  // R5
  predec_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !ld_en_i && ea_i[5:3] == 3'b111) |=> (r_sel == $past(addr_o)));
endmodule

bind dsp_ea_gen dsp_ea_gen_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .exec_i     (exec_i),
  .ea_i       (ea_i),
  .ld_en_i    (ld_en_i),
  .addr_o     (addr_o),
  .imm_o      (imm_o),
  .need_ext_o (need_ext_o),
  .illegal_o  (illegal_o),
  .r_flat_o   (r_flat_o),
  .n_flat_o   (n_flat_o)
);

// File: tb/dsp_ea_gen_bench.sv
module dsp_ea_gen_bench;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            exec_i = 1'b0;
  logic [5:0]      ea_i = '0;
  logic [AW-1:0]   ext_i = '0;
  logic            ld_en_i = 1'b0;
  logic            ld_sel_i = 1'b0;
  logic [2:0]      ld_idx_i = '0;
  logic [AW-1:0]   ld_data_i = '0;
  logic [AW-1:0]   addr_o;
  logic            imm_o, need_ext_o, illegal_o;
  logic [8*AW-1:0] r_flat_o, n_flat_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [AW-1:0] mr [8];
  logic [AW-1:0] mn [8];

  always #2 clk = ~clk;

  dsp_ea_gen #(.AW(AW)) u_dsp_ea_gen (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .ea_i(ea_i), .ext_i(ext_i),
    .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i),
    .addr_o(addr_o), .imm_o(imm_o), .need_ext_o(need_ext_o), .illegal_o(illegal_o),
    .r_flat_o(r_flat_o), .n_flat_o(n_flat_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [5:0] ea);
    case (ea[5:3])
      3'b000, 3'b001: return "R2";
      3'b010, 3'b011: return "R3";
      3'b100, 3'b101: return "R4";
      3'b111:         return "R5";
      default: return (ea[2:0] == 3'b000) ? "R6" : (ea[2:0] == 3'b100) ? "R7" : "R8";
    endcase
  endfunction

  function automatic logic [AW-1:0] f_addr(input logic [5:0] ea, input logic [AW-1:0] ext);
    logic [AW-1:0] r, n;
    r = mr[ea[2:0]];
    n = mn[ea[2:0]];
    case (ea[5:3])
      3'b101: return r + n;
      3'b111: return r - 1;
      3'b110: return (ea[2:0] == 3'b000 || ea[2:0] == 3'b100) ? ext : '0;
      default: return r;
    endcase
  endfunction

  function automatic logic [AW-1:0] f_next(input logic [5:0] ea);
    logic [AW-1:0] r, n;
    r = mr[ea[2:0]];
    n = mn[ea[2:0]];
    case (ea[5:3])
      3'b000: return r - n;
      3'b001: return r + n;
      3'b010, 3'b111: return r - 1;
      3'b011: return r + 1;
      default: return r;
    endcase
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < 8; i++) begin
      chk(r_flat_o[i*AW +: AW] == mr[i], req, 32'(r_flat_o[i*AW +: AW]), 32'(mr[i]));
      chk(n_flat_o[i*AW +: AW] == mn[i], req, 32'(n_flat_o[i*AW +: AW]), 32'(mn[i]));
    end
  endtask

  // One operation: check state left by the previous edge, drive, check comb outputs, update model.
  task automatic op(input logic [5:0] ea, input logic [AW-1:0] ext, input bit ex,
                    input bit le, input bit ls, input logic [2:0] li, input logic [AW-1:0] ld,
                    input string req);
    bit is_ext, is_imm, is_ill;
    @(negedge clk);
    check_regs(req);
    ea_i = ea; ext_i = ext; exec_i = ex;
    ld_en_i = le; ld_sel_i = ls; ld_idx_i = li; ld_data_i = ld;
    #1;
    is_ext = (ea[5:3] == 3'b110) && (ea[2:0] == 3'b000 || ea[2:0] == 3'b100);
    is_imm = is_ext && ea[2];
    is_ill = (ea[5:3] == 3'b110) && !is_ext;
    chk(addr_o == f_addr(ea, ext), req_of(ea), 32'(addr_o), 32'(f_addr(ea, ext)));
    chk({need_ext_o, imm_o, illegal_o} == {is_ext, is_imm, is_ill}, req_of(ea),
        32'({need_ext_o, imm_o, illegal_o}), 32'({is_ext, is_imm, is_ill}));
    if (ex) mr[ea[2:0]] = f_next(ea);
    if (le) begin
      if (ls) mn[li] = ld;
      else    mr[li] = ld;
    end
  endtask

  task automatic load(input bit ls, input logic [2:0] li, input logic [AW-1:0] d);
    op(6'o40, '0, 1'b0, 1'b1, ls, li, d, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin mr[i] = '0; mn[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check_regs("R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R11 preload
    load(0, 3, 8'h10); load(1, 3, 8'h05);
    load(0, 0, 8'h00); load(1, 0, 8'h03);
    load(0, 1, 8'hFF); load(1, 1, 8'h02);
    load(0, 2, 8'hF0); load(1, 2, 8'h20);
    // R2 post-offset
    op(6'o03, 0, 1, 0, 0, 0, 0, "R2");
    op(6'o13, 0, 1, 0, 0, 0, 0, "R2");
    // R3 post unit
    op(6'o23, 0, 1, 0, 0, 0, 0, "R3");
    op(6'o33, 0, 1, 0, 0, 0, 0, "R3");
    // R4 no update
    op(6'o43, 0, 1, 0, 0, 0, 0, "R4");
    op(6'o53, 0, 1, 0, 0, 0, 0, "R4");
    // R5 pre-decrement
    op(6'o73, 0, 1, 0, 0, 0, 0, "R5");
    // R9 wrap cases
    op(6'o20, 0, 1, 0, 0, 0, 0, "R9");
    op(6'o31, 0, 1, 0, 0, 0, 0, "R9");
    op(6'o52, 0, 1, 0, 0, 0, 0, "R9");
    op(6'o12, 0, 1, 0, 0, 0, 0, "R9");
    op(6'o00, 0, 1, 0, 0, 0, 0, "R9");
    load(0, 4, 8'h00);
    op(6'o74, 0, 1, 0, 0, 0, 0, "R9");
    // R6 R7 R8
    op(6'o60, 8'hA5, 1, 0, 0, 0, 0, "R6");
    op(6'o64, 8'h3C, 1, 0, 0, 0, 0, "R7");
    for (int c = 1; c < 8; c++)
      if (c != 4) op(6'(8'o60 + c), 8'h77, 1, 0, 0, 0, 0, "R8");
    // R10 exec low
    op(6'o13, 0, 0, 0, 0, 0, 0, "R10");
    op(6'o73, 0, 0, 0, 0, 0, 0, "R10");
    // R11 load beats update on same register
    op(6'o33, 0, 1, 1, 0, 3, 8'h99, "R11");
    op(6'o13, 0, 1, 1, 1, 3, 8'h44, "R11");

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [5:0] ea;
      ea = 6'($urandom);
      op(ea, AW'($urandom), ($urandom % 5) != 0, ($urandom % 5) == 0, 1'($urandom),
         3'($urandom), AW'($urandom), req_of(ea));
    end
    @(negedge clk);
    exec_i = 1'b0; ld_en_i = 1'b0;
    check_regs("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule